// File: doc/BRIEF.md
# Glitch-Free Divide-by-1/2 Clock Stage

This block sits behind a clock switch and feeds several output banks. Each bank receives the same switched clock. Each bank passes it on either at the input rate or at half the input rate, as its own ratio-select bit chooses. The switched clock and the ratio selects are oversampled by a fast system clock `clk`. Each bank output is a registered waveform in that domain. A ratio change never cuts a pulse short. The new ratio is taken on only at the point where the output falls and ends a period of the old ratio.

The upstream switch also provides a bad-input flag. While it is raised every bank output is pinned low, and a pending ratio choice is taken on at once. When the flag drops, each bank starts from low in its newly chosen ratio. Its first high phase begins on the next input rising edge. The select and clock inputs are plain level signals with no handshake: the block samples them continuously and never applies back-pressure.

Top module: `fdiv_ratio_sel`

## Requirements
- R1: While reset is asserted, and right after it, every bank output is low and every bank runs in the divide-by-1 ratio.
- R2: The banks are independent: the select of one bank has no effect on the waveform of another bank.
- R3: In ratio select 0 (divide by 1) the output goes high on each input rising edge and low on each input falling edge, so its high and low times equal those of the input.
- R4: In ratio select 1 (divide by 2) the output toggles on each input rising edge, so it is high for one full input period and low for the next: the duty cycle is exactly 50 % whatever the input duty cycle.
- R5: A select change is adopted only at a high-to-low output transition that ends a period, so that no high pulse is ever shorter than a full high phase of either ratio.
- R6: At the first clock edge that samples the bad flag high, every output goes low, and it stays low as long as the flag is high.
- R7: A select changed while the bad flag is high is in force when the flag drops. The output leaves low only on the next input rising edge and follows the new ratio from that edge on.
- R8: Each select bit passes through a two-flop synchroniser: a select value applied before clock edge n is the one a bank may adopt at edge n+2.
- R9: The input clock passes through a two-flop synchroniser and an edge detector: an input edge applied before clock edge n moves the output at edge n+2, the third edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 1 | Switched input clock, sampled as a level |
| src_bad | input | 1 | Bad-input flag from the switch, synchronous to clk |
| div_sel | input | NUM_BANKS | Per-bank ratio select: 0 divide by 1, 1 divide by 2 |
| clk_out | output | NUM_BANKS | Per-bank output waveform |

## Verification
The bench toggles a bank's select in the middle of high phases and checks that every high pulse lasts exactly a full phase of one ratio. A design that switched ratio at once would emit a shortened pulse or a stretched one. Asymmetric input duty cycles show whether divide-by-2 keeps 50 %. If the design used the input level instead of edge counting, the divide-by-2 high time would follow the input high time. Ratio changes made while the bad flag holds the input stalled must show up on recovery. A design that latched them only at a period end would restart in the old ratio. A design that followed the input level at recovery would rise without a fresh input edge.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic {
    RATIO_DIV1 = 1'b0,
    RATIO_DIV2 = 1'b1
  } ratio_e;
endpackage

// File: rtl/fdiv_sync.sv
module fdiv_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/fdiv_edge.sv
module fdiv_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;
endmodule

// File: rtl/fdiv_bank.sv
module fdiv_bank
  import fdiv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic src_rise,
  input  logic src_fall,
  input  logic bad,
  input  logic sel,
  output logic out
);
  ratio_e mode_q;
  logic   out_q;
  logic   out_d;
  logic   period_end;

  always_comb begin
    out_d = out_q;
    unique case (mode_q)
      RATIO_DIV1: begin
        if (src_rise)      out_d = 1'b1;
        else if (src_fall) out_d = 1'b0;
      end
      RATIO_DIV2: begin
        if (src_rise) out_d = ~out_q;
      end
      default: out_d = 1'b0;
    endcase
    if (bad) out_d = 1'b0;
  end

  assign period_end = out_q & ~out_d & ~bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RATIO_DIV1;
      out_q  <= 1'b0;
    end else begin
      out_q <= out_d;
      if (bad || period_end) mode_q <= ratio_e'(sel);
    end
  end

  assign out = out_q;
endmodule

// File: rtl/fdiv_ratio_sel.sv
module fdiv_ratio_sel #(
  parameter int NUM_BANKS  = 2,
  parameter int SRC_STAGES = 2,
  parameter int SEL_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 src_in,
  input  logic                 src_bad,
  input  logic [NUM_BANKS-1:0] div_sel,
  output logic [NUM_BANKS-1:0] clk_out
);
  logic                 src_s;
  logic                 src_rise;
  logic                 src_fall;
  logic [NUM_BANKS-1:0] sel_s;

  fdiv_sync #(.WIDTH(1), .STAGES(SRC_STAGES)) u_src_sync (
    .clk(clk), .rst_n(rst_n), .d(src_in), .q(src_s)
  );

  fdiv_edge u_src_edge (
    .clk(clk), .rst_n(rst_n), .lvl(src_s), .rise(src_rise), .fall(src_fall)
  );

  fdiv_sync #(.WIDTH(NUM_BANKS), .STAGES(SEL_STAGES)) u_sel_sync (
    .clk(clk), .rst_n(rst_n), .d(div_sel), .q(sel_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fdiv_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_rise (src_rise),
      .src_fall (src_fall),
      .bad      (src_bad),
      .sel      (sel_s[b]),
      .out      (clk_out[b])
    );
  end
endmodule

// File: rtl/fdiv_ratio_sel_chk.sv
module fdiv_ratio_sel_chk #(
  parameter int NUM_BANKS = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 src_in,
  input logic                 src_bad,
  input logic [NUM_BANKS-1:0] clk_out
);
  logic [2:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_LOW: assert (clk_out == '0); // R1
  end

  AST_BAD_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    src_bad |=> (clk_out == '0)); // R6

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    AST_RISE_ON_SRC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clk_out[b]) && since_rst >= 3'd5) |->
        ($past(src_in, 3) && !$past(src_in, 4) && !$past(src_bad))); // R9

    AST_FALL_ON_SRC_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(clk_out[b]) && !$past(src_bad) && since_rst >= 3'd5) |->
        ($past(src_in, 3) != $past(src_in, 4))); // R5
  end
endmodule

bind fdiv_ratio_sel fdiv_ratio_sel_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_bad(src_bad), .clk_out(clk_out)
);

// File: tb/fdiv_ratio_sel_bench.sv
module fdiv_ratio_sel_bench;
  localparam int NB = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          src_in = 1'b0;
  logic          src_bad = 1'b0;
  logic [NB-1:0] div_sel = '0;
  logic [NB-1:0] clk_out;

  int    n_chk = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  fdiv_ratio_sel #(.NUM_BANKS(NB)) u_fdiv_ratio_sel (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .src_bad(src_bad),
    .div_sel(div_sel), .clk_out(clk_out)
  );

  // Behavioural reference: input histories, then per-bank waveform rules.
  bit          srch [4];
  bit [NB-1:0] selh [4];
  bit [NB-1:0] m_out;
  bit [NB-1:0] m_div2;
  bit          bad_seen;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin srch[i] = 0; selh[i] = '0; end
      m_out = '0; m_div2 = '0; bad_seen = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin srch[i] = srch[i-1]; selh[i] = selh[i-1]; end
      srch[0] = src_in;
      selh[0] = div_sel;
      bad_seen = src_bad;
      for (int b = 0; b < NB; b++) begin
        bit up, dn, nx;
        up = srch[2] && !srch[3];
        dn = !srch[2] && srch[3];
        if (src_bad) begin
          m_out[b] = 0;
          m_div2[b] = selh[2][b];
        end else begin
          if (m_div2[b]) nx = up ? !m_out[b] : m_out[b];
          else           nx = up ? 1'b1 : (dn ? 1'b0 : m_out[b]);
          if (m_out[b] && !nx) m_div2[b] = selh[2][b];
          m_out[b] = nx;
        end
      end
    end
  end

  // Pulse measurement seen at the ports.
  int last_hi [NB], last_lo [NB], run_hi [NB], run_lo [NB], first_hi [NB];
  bit odd_pulse;
  int hi_in_bad;
  bit [NB-1:0] prev_out;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_chk++;
      if (clk_out !== m_out) begin
        n_bad++;
        $display("FAIL %s: cycle compare clk_out=%b expected=%b", cur_req, clk_out, m_out);
      end
      if (bad_seen && clk_out != '0) hi_in_bad++;
      for (int b = 0; b < NB; b++) begin
        if (clk_out[b]) begin
          if (!prev_out[b]) begin last_lo[b] = run_lo[b]; run_hi[b] = 0; end
          run_hi[b]++;
        end else begin
          if (prev_out[b]) begin
            last_hi[b] = run_hi[b];
            if (first_hi[b] == 0) first_hi[b] = run_hi[b];
            if (run_hi[b] != 3 && run_hi[b] != 8) odd_pulse = 1;
            run_lo[b] = 0;
          end
          run_lo[b]++;
        end
      end
      prev_out = clk_out;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic src_period(input int hi, input int lo);
    src_in = 1'b1; cyc(hi);
    src_in = 1'b0; cyc(lo);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1'b1;
      summary();
    end
  end

  initial begin
    cyc(5);
    check("R1", int'(clk_out), 0);
    rst_n = 1'b1;
    cyc(3);
    check("R1", int'(clk_out), 0);

    // R9 latency: input edge to output edge
    cur_req = "R9";
    src_in = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R9", int'(clk_out), 0);
    @(posedge clk); #1;
    check("R9", int'(clk_out), 3);
    cyc(2); src_in = 1'b0; cyc(5);

    cur_req = "R3";
    repeat (6) src_period(3, 5);
    check("R3", last_hi[0], 3);
    check("R3", last_lo[0], 5);
    check("R3", last_hi[1], 3);

    cur_req = "R4";
    div_sel = 2'b11;
    repeat (6) src_period(3, 5);
    check("R4", last_hi[0], 8);
    check("R4", last_lo[0], 8);
    repeat (6) src_period(2, 6);
    check("R4", last_hi[1], 8);
    check("R4", last_lo[1], 8);
    repeat (6) src_period(6, 2);
    check("R4", last_hi[0], 8);
    check("R4", last_lo[0], 8);

    cur_req = "R2";
    div_sel = 2'b01;
    repeat (6) src_period(3, 5);
    check("R2", last_hi[0], 8);
    check("R2", last_hi[1], 3);
    check("R2", last_lo[1], 5);

    cur_req = "R5/R8";
    odd_pulse = 0;
    for (int k = 0; k < 10; k++) begin
      src_in = 1'b1; cyc(1);
      div_sel[0] = ~div_sel[0];
      cyc(2); src_in = 1'b0; cyc(1 + (k % 3));
      if (k % 2 == 0) div_sel[0] = ~div_sel[0];
      cyc(4 - (k % 3));
    end
    repeat (4) src_period(3, 5);
    check("R5", int'(odd_pulse), 0);

    cur_req = "R6";
    div_sel = 2'b10;
    repeat (3) src_period(3, 5);
    hi_in_bad = 0;
    src_in = 1'b1; cyc(1);
    src_bad = 1'b1;
    repeat (4) src_period(3, 5);
    check("R6", hi_in_bad, 0);
    check("R6", int'(clk_out), 0);

    cur_req = "R7";
    src_in = 1'b0; cyc(6);
    div_sel = 2'b01;
    cyc(4);
    src_bad = 1'b0;
    first_hi[0] = 0; first_hi[1] = 0;
    cyc(4);
    check("R7", int'(clk_out), 0);
    repeat (5) src_period(3, 5);
    check("R7", first_hi[0], 8);
    check("R7", first_hi[1], 3);

    cyc(4);
    done = 1'b1;
    summary();
  end
endmodule